// File: doc/BRIEF.md
# Power-Fail Save and Power-Return Restore Sequencer

This block supervises a battery-free nonvolatile SRAM model. Two digital flags from outside comparators tell it whether the supply is below the switch threshold and whether it is below the lower reset threshold. From these flags the block decides when to copy the working SRAM array into its shadow (nonvolatile) array. It also decides when to copy the shadow back into the SRAM once power returns. It owns both arrays and a single-word access port. It also watches and drives an open-drain busy line, seen as a drive-low output plus a sensed line level.

A dip that stays above the reset level and then recovers keeps the SRAM contents and needs no restore. A drop below the reset level, or power-up itself, leaves a restore request pending, and that restore runs once the supply is back above the switch level. An automatic save happens only when the SRAM has been written since the last save or restore. The same rule applies to a save requested by pulling the busy line low from outside. Software save and restore requests come in as decoded pulses. A software save runs whether or not anything was written. A static configuration input turns off automatic saving.

Top module: `nvPowerSequencer`

## Requirements
- R1: Reset models power-up. During and right after reset, busyDriveLow=0, sramInhibit=1, and storeStart and recallStart are both 0. A restore request is pending from reset. recallStart does not pulse while belowSwitch=1. recallStart pulses on the second clock edge after belowSwitch falls.
- R2: A cycle with belowReset=1 leaves a restore pending, and that restore runs after belowSwitch next falls. A dip with belowSwitch=1 and belowReset never 1 gives no recallStart.
- R3: With inhibitAuto=0, a rise of belowSwitch drives busyDriveLow=1 for exactly WIN_CYC cycles. If no accepted write has happened since the last save or restore, the line is then released and no save starts.
- R4: An automatic save starts with a one-cycle storeStart at the end of the window. This requires an accepted write since the last save or restore, and the busy line sensed low during the window. busyDriveLow and sramInhibit then stay 1 for STORE_CYC cycles.
- R5: If busySense stays 1 throughout the window because something overdrives the line, the save is abandoned. No storeStart occurs, and the written-since flag is kept.
- R6: A save copies every SRAM word into the shadow array. A restore copies every shadow word back into the SRAM and holds sramInhibit=1 for RESTORE_CYC cycles, marked by a one-cycle recallStart. Reset clears both arrays to zero.
- R7: The written-since flag is set by any accepted write and cleared at the start of every save or restore.
- R8: A write is ignored when belowSwitch=1, when busySense=0, or when sramInhibit=1. sramInhibit is 1 during supply-low hold, save, post-save hold and restore. A read with sramInhibit=1 returns 0.
- R9: With the supply good and the block idle, busySense=0 starts a save only when the written-since flag is set. After that save, sramInhibit stays 1 until busySense returns to 1.
- R10: A software save runs even with no write since the last save or restore. Software save and restore pulses are ignored while belowSwitch=1.
- R11: With inhibitAuto=1, a rise of belowSwitch neither drives the busy line nor starts a save. Software saves still work.
- R12: A read (memEn=1, memWe=0) returns the addressed word on memRdata after the next clock edge. A write (memEn=1, memWe=1) takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-up) |
| belowSwitch | input | 1 | Supply below switch threshold |
| belowReset | input | 1 | Supply below reset threshold |
| inhibitAuto | input | 1 | Static: disables automatic saving |
| busySense | input | 1 | Sensed busy line level (0 = low) |
| busyDriveLow | output | 1 | Pull busy line low (open drain) |
| swStoreReq | input | 1 | Decoded software save request pulse |
| swRecallReq | input | 1 | Decoded software restore request pulse |
| memEn | input | 1 | SRAM access enable |
| memWe | input | 1 | SRAM write (1) or read (0) |
| memAddr | input | ADDR_W | SRAM word address |
| memWdata | input | DATA_W | SRAM write data |
| memRdata | output | DATA_W | SRAM read data, registered |
| sramInhibit | output | 1 | SRAM access disabled |
| storeStart | output | 1 | One-cycle pulse: save begins |
| recallStart | output | 1 | One-cycle pulse: restore begins |

## Verification
The bench builds the block with an 8-word array, a 4-cycle busy window, a 12-cycle save and a 10-cycle restore. With these values a full copy fits inside each operation, and every phase boundary can be counted to the exact cycle. The short durations also let one run cover all of the following: power-up, brown-out with and without writes, overdrive abandon, deep drop, the external busy pull and the inhibit mode. The shadow contents are checked by overwriting the SRAM, restoring, and comparing against a snapshot taken at save time.

// File: rtl/nvSeqPkg.sv
`timescale 1ns/1ps
package nvSeqPkg;

  typedef enum logic [2:0] {
    S_DOWN   = 3'd0,
    S_IDLE   = 3'd1,
    S_WINDOW = 3'd2,
    S_STORE  = 3'd3,
    S_HOLD   = 3'd4,
    S_RECALL = 3'd5
  } seqState_t;

  typedef struct packed {
    logic toShadow;
    logic toSram;
    logic clearDirty;
    logic inhibit;
  } dpStrobe_t;

endpackage

// File: rtl/nvSeqCtrl.sv
`timescale 1ns/1ps
module nvSeqCtrl
  import nvSeqPkg::*;
#(
  parameter int WIN_CYC     = 200,
  parameter int STORE_CYC   = 2000000,
  parameter int RESTORE_CYC = 110000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      belowSwitch,
  input  logic      belowReset,
  input  logic      inhibitAuto,
  input  logic      busySense,
  input  logic      swStoreReq,
  input  logic      swRecallReq,
  input  logic      dirty,
  output dpStrobe_t strobe,
  output logic      storeStart,
  output logic      recallStart,
  output logic      busyDriveLow,
  output logic      sramInhibit
);

  localparam int MAX_SR = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
  localparam int MAXC   = (MAX_SR > WIN_CYC) ? MAX_SR : WIN_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  seqState_t        state, nextState;
  logic [CNT_W-1:0] cnt, limitM1;
  logic             lastCyc, timedState;
  logic             recallPend, seenLow;
  logic             goStore, goRecall;
  logic             storeStartQ, recallStartQ;

  always_comb begin
    case (state)
      S_WINDOW: limitM1 = CNT_W'(WIN_CYC - 1);
      S_STORE:  limitM1 = CNT_W'(STORE_CYC - 1);
      S_RECALL: limitM1 = CNT_W'(RESTORE_CYC - 1);
      default:  limitM1 = '0;
    endcase
  end

  assign timedState = (state == S_WINDOW) || (state == S_STORE) || (state == S_RECALL);
  assign lastCyc    = timedState && (cnt == limitM1);

  // Next-state decision; supply loss outranks every request
  always_comb begin
    nextState = state;
    goStore   = 1'b0;
    goRecall  = 1'b0;
    case (state)
      S_DOWN: begin
        if (!belowSwitch) nextState = S_IDLE;
      end
      S_IDLE: begin
        if (belowSwitch)      nextState = inhibitAuto ? S_DOWN : S_WINDOW;
        else if (recallPend)  goRecall = 1'b1;
        else if (swStoreReq)  goStore  = 1'b1;
        else if (swRecallReq) goRecall = 1'b1;
        else if (!busySense && dirty) goStore = 1'b1;
      end
      S_WINDOW: begin
        if (lastCyc) begin
          if ((seenLow || !busySense) && dirty) goStore = 1'b1;
          else nextState = S_DOWN;
        end
      end
      S_STORE: begin
        if (lastCyc) nextState = S_HOLD;
      end
      S_HOLD: begin
        if (busySense) nextState = belowSwitch ? S_DOWN : S_IDLE;
      end
      S_RECALL: begin
        if (lastCyc) nextState = S_IDLE;
      end
      default: nextState = S_DOWN;
    endcase
    if (goStore)  nextState = S_STORE;
    if (goRecall) nextState = S_RECALL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= S_DOWN;
      cnt          <= '0;
      recallPend   <= 1'b1;
      seenLow      <= 1'b0;
      storeStartQ  <= 1'b0;
      recallStartQ <= 1'b0;
    end else begin
      state        <= nextState;
      storeStartQ  <= goStore;
      recallStartQ <= goRecall;
      if (nextState != state) cnt <= '0;
      else if (timedState)    cnt <= cnt + 1'b1;
      if (state != S_WINDOW)  seenLow <= 1'b0;
      else if (!busySense)    seenLow <= 1'b1;
      if (belowReset)         recallPend <= 1'b1;
      else if (goRecall)      recallPend <= 1'b0;
    end
  end

  assign storeStart   = storeStartQ;
  assign recallStart  = recallStartQ;
  assign busyDriveLow = (state == S_WINDOW) || (state == S_STORE);
  assign sramInhibit  = (state == S_DOWN) || (state == S_STORE) ||
                        (state == S_HOLD) || (state == S_RECALL);

  always_comb begin
    strobe            = '0;
    strobe.toShadow   = (state == S_STORE);
    strobe.toSram     = (state == S_RECALL);
    strobe.clearDirty = storeStartQ || recallStartQ;
    strobe.inhibit    = sramInhibit;
  end

endmodule

// File: rtl/nvSeqDatapath.sv
`timescale 1ns/1ps
module nvSeqDatapath
  import nvSeqPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              belowSwitch,
  input  logic              busySense,
  input  logic              memEn,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] memRdata,
  output logic              dirty
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sramArr   [DEPTH];
  logic [DATA_W-1:0] shadowArr [DEPTH];
  logic [ADDR_W:0]   idx;
  logic [ADDR_W-1:0] idxLow;
  logic              idxValid, copying, writeOk;

  assign copying  = strobe.toShadow || strobe.toSram;
  assign idxValid = !idx[ADDR_W];
  assign idxLow   = idx[ADDR_W-1:0];
  assign writeOk  = memEn && memWe && !strobe.inhibit && !belowSwitch && busySense;

  // Copy pointer walks the array once per save or restore
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idx <= '0;
    else if (!copying)   idx <= '0;
    else if (idxValid)   idx <= idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) sramArr[i] <= '0;
    end else if (strobe.toSram && idxValid) begin
      sramArr[idxLow] <= shadowArr[idxLow];
    end else if (writeOk) begin
      sramArr[memAddr] <= memWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) shadowArr[i] <= '0;
    end else if (strobe.toShadow && idxValid) begin
      shadowArr[idxLow] <= sramArr[idxLow];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memRdata <= '0;
    end else if (memEn && !memWe) begin
      memRdata <= strobe.inhibit ? '0 : sramArr[memAddr];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  dirty <= 1'b0;
    else if (strobe.clearDirty) dirty <= 1'b0;
    else if (writeOk)           dirty <= 1'b1;
  end

endmodule

// File: rtl/nvPowerSequencer.sv
`timescale 1ns/1ps
module nvPowerSequencer
  import nvSeqPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int WIN_CYC     = 200,
  parameter int STORE_CYC   = 2000000,
  parameter int RESTORE_CYC = 110000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              belowSwitch,
  input  logic              belowReset,
  input  logic              inhibitAuto,
  input  logic              busySense,
  output logic              busyDriveLow,
  input  logic              swStoreReq,
  input  logic              swRecallReq,
  input  logic              memEn,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] memRdata,
  output logic              sramInhibit,
  output logic              storeStart,
  output logic              recallStart
);

  dpStrobe_t strobe;
  logic      dirty;

  nvSeqCtrl #(
    .WIN_CYC(WIN_CYC), .STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .belowSwitch(belowSwitch), .belowReset(belowReset),
    .inhibitAuto(inhibitAuto), .busySense(busySense), .swStoreReq(swStoreReq),
    .swRecallReq(swRecallReq), .dirty(dirty), .strobe(strobe),
    .storeStart(storeStart), .recallStart(recallStart),
    .busyDriveLow(busyDriveLow), .sramInhibit(sramInhibit)
  );

  nvSeqDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .belowSwitch(belowSwitch),
    .busySense(busySense), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .dirty(dirty)
  );

endmodule

// File: rtl/nvPowerSequencerChecker.sv
`timescale 1ns/1ps
module nvPowerSequencerChecker (
  input logic clk,
  input logic rstN,
  input logic belowSwitch,
  input logic inhibitAuto,
  input logic busyDriveLow,
  input logic sramInhibit,
  input logic storeStart,
  input logic recallStart
);

  // R1 / R2: a restore only begins once the supply was good on the deciding cycle
  p_recall_after_switch_r1: assert property (@(posedge clk) disable iff (!rstN)
    recallStart |-> !$past(belowSwitch));

  // R4: a save holds the busy line low and blocks SRAM access from its first cycle
  p_store_holds_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |-> (busyDriveLow && sramInhibit));

  // R4: the save start marker lasts a single cycle
  p_store_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |=> !storeStart);

  // R6: a restore blocks SRAM access and leaves the busy line alone
  p_recall_inhibit_r6: assert property (@(posedge clk) disable iff (!rstN)
    recallStart |-> (sramInhibit && !busyDriveLow));

  // R11: with auto saving disabled, the busy line is driven only by a running save
  p_no_window_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inhibitAuto && busyDriveLow) |-> sramInhibit);

  // R10: a save that does not follow a busy window was requested with supply good
  p_req_store_supply_r10: assert property (@(posedge clk) disable iff (!rstN)
    (storeStart && !$past(busyDriveLow)) |-> !$past(belowSwitch));

endmodule

bind nvPowerSequencer nvPowerSequencerChecker u_chk (
  .clk(clk), .rstN(rstN), .belowSwitch(belowSwitch), .inhibitAuto(inhibitAuto),
  .busyDriveLow(busyDriveLow), .sramInhibit(sramInhibit),
  .storeStart(storeStart), .recallStart(recallStart)
);

// File: tb/tb_nvPowerSequencer.sv
`timescale 1ns/1ps
module tb_nvPowerSequencer;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WIN    = 4;
  localparam int STC    = 12;
  localparam int RSC    = 10;

  logic clk, rstN, belowSwitch, belowReset, inhibitAuto, busySense, busyDriveLow;
  logic swStoreReq, swRecallReq, memEn, memWe, sramInhibit, storeStart, recallStart;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata, memRdata;
  logic extPull, overdrive;

  int nTests = 0, nFail = 0;
  int nStore = 0, nRecall = 0, busyCyc = 0, inhCyc = 0;
  logic [DATA_W-1:0] refMem [DEPTH];
  logic [DATA_W-1:0] snap   [DEPTH];

  // Open-drain line: pulled up, pulled low by either side, unless overdriven high
  assign busySense = overdrive | ~(busyDriveLow | extPull);

  nvPowerSequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_CYC(WIN), .STORE_CYC(STC), .RESTORE_CYC(RSC)
  ) dut (
    .clk(clk), .rstN(rstN), .belowSwitch(belowSwitch), .belowReset(belowReset),
    .inhibitAuto(inhibitAuto), .busySense(busySense), .busyDriveLow(busyDriveLow),
    .swStoreReq(swStoreReq), .swRecallReq(swRecallReq), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .sramInhibit(sramInhibit), .storeStart(storeStart), .recallStart(recallStart)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (storeStart)   nStore++;
    if (recallStart)  nRecall++;
    if (busyDriveLow) busyCyc++;
    if (sramInhibit)  inhCyc++;
  end

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    memEn = 1'b1; memWe = 1'b1; memAddr = ADDR_W'(a); memWdata = DATA_W'(d);
    tick(1);
    memEn = 1'b0; memWe = 1'b0;
  endtask

  task automatic rdChk(input int a, input int exp, input string tag);
    memEn = 1'b1; memWe = 1'b0; memAddr = ADDR_W'(a);
    tick(1);
    memEn = 1'b0;
    check(tag, int'(memRdata), exp);
  endtask

  function automatic int nextVal(input int a, input int salt);
    return (a * 37 + salt * 11 + 5) & 8'hFF;
  endfunction

  task automatic readAll(input string tag);
    for (int a = 0; a < DEPTH; a++) rdChk(a, int'(refMem[a]), tag);
  endtask

  task automatic pulseSw(input bit isStore);
    if (isStore) swStoreReq = 1'b1; else swRecallReq = 1'b1;
    tick(1);
    swStoreReq = 1'b0; swRecallReq = 1'b0;
  endtask

  initial begin
    #100000;
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int s0, r0, b0, i0;
    void'($urandom(32'd11));
    rstN = 1'b0; belowSwitch = 1'b1; belowReset = 1'b1; inhibitAuto = 1'b0;
    extPull = 1'b0; overdrive = 1'b0; swStoreReq = 1'b0; swRecallReq = 1'b0;
    memEn = 1'b0; memWe = 1'b0; memAddr = '0; memWdata = '0;
    for (int a = 0; a < DEPTH; a++) refMem[a] = '0;
    tick(3);
    // R1 reset state
    check("R1 reset busyDriveLow", busyDriveLow, 0);
    check("R1 reset sramInhibit", sramInhibit, 1);
    check("R1 reset starts", {storeStart, recallStart}, 0);
    rstN = 1'b1; tick(2); belowReset = 1'b0; tick(5);
    check("R1 no restore while below switch", nRecall, 0);
    belowSwitch = 1'b0; tick(2);
    check("R1 restore pulse on second edge", recallStart, 1);
    tick(RSC + 2);
    check("R1 one power-up restore", nRecall, 1);
    readAll("R6 restored zeros");

    // R12 random traffic against the reference array
    wr(0, 8'h5A); refMem[0] = 8'h5A;
    for (int k = 0; k < 60; k++) begin
      int a, d;
      a = int'($urandom % DEPTH);
      if ($urandom % 2 == 1) begin
        d = int'($urandom & 8'hFF); wr(a, d); refMem[a] = DATA_W'(d);
      end else begin
        rdChk(a, int'(refMem[a]), "R12 random read");
      end
    end
    readAll("R12 full readback");

    // Shallow dip with writes: window, save, no restore
    for (int a = 0; a < DEPTH; a++) snap[a] = refMem[a];
    s0 = nStore; r0 = nRecall; b0 = busyCyc;
    belowSwitch = 1'b1; tick(1);
    wr(0, 8'hA5);
    tick(WIN + STC + 4);
    check("R4 auto save ran", nStore - s0, 1);
    check("R4 busy low window plus save", busyCyc - b0, WIN + STC);
    belowSwitch = 1'b0; tick(4);
    check("R2 shallow dip no restore", nRecall - r0, 0);
    readAll("R8 write during dip ignored");

    // Overwrite, then software restore brings the saved snapshot back
    for (int a = 0; a < DEPTH; a++) begin
      wr(a, nextVal(a, 1)); refMem[a] = DATA_W'(nextVal(a, 1));
    end
    i0 = inhCyc; r0 = nRecall;
    pulseSw(1'b0); tick(RSC + 3);
    check("R6 restore inhibit length", inhCyc - i0, RSC);
    check("R6 software restore pulse", nRecall - r0, 1);
    for (int a = 0; a < DEPTH; a++) refMem[a] = snap[a];
    readAll("R6 shadow contents restored");

    // Dip with nothing written since restore
    s0 = nStore; b0 = busyCyc;
    belowSwitch = 1'b1; tick(WIN + 6);
    check("R3 window length", busyCyc - b0, WIN);
    check("R7 no save when clean", nStore - s0, 0);
    check("R3 busy released", busyDriveLow, 0);
    belowSwitch = 1'b0; tick(3);

    // Overdriven busy line abandons the save, dirty flag survives
    wr(1, 8'h3C); refMem[1] = 8'h3C;
    s0 = nStore; overdrive = 1'b1; belowSwitch = 1'b1; tick(WIN + 6);
    check("R5 overdrive abandons save", nStore - s0, 0);
    check("R5 busy released after abandon", busyDriveLow, 0);
    belowSwitch = 1'b0; overdrive = 1'b0; tick(3);
    belowSwitch = 1'b1; tick(WIN + STC + 6);
    check("R7 written flag kept after abandon", nStore - s0, 1);
    belowSwitch = 1'b0; tick(3);

    // Deep drop: save, then restore on recovery
    wr(2, 8'hC3); refMem[2] = 8'hC3;
    s0 = nStore; r0 = nRecall;
    belowSwitch = 1'b1; tick(WIN + STC + 6);
    belowReset = 1'b1; tick(2); belowReset = 1'b0; tick(3);
    check("R2 restore waits for switch level", nRecall - r0, 0);
    belowSwitch = 1'b0; tick(RSC + 5);
    check("R2 deep drop restores", nRecall - r0, 1);
    check("R4 deep drop saved", nStore - s0, 1);
    readAll("R6 deep drop contents");

    // External busy pull
    s0 = nStore;
    extPull = 1'b1; tick(4);
    check("R9 clean pull ignored", nStore - s0, 0);
    wr(3, 8'h99);
    extPull = 1'b0; tick(2);
    rdChk(3, int'(refMem[3]), "R8 write with busy low ignored");
    wr(3, 8'h77); refMem[3] = 8'h77;
    extPull = 1'b1; tick(STC + 4);
    check("R9 pull saves when written", nStore - s0, 1);
    check("R9 held off while line low", sramInhibit, 1);
    extPull = 1'b0; tick(2);
    check("R9 access back after release", sramInhibit, 0);
    rdChk(3, 8'h77, "R8 read after pull save");

    // Software save unconditional, software requests blocked in dip
    s0 = nStore;
    pulseSw(1'b1); tick(STC + 4);
    check("R10 software save without writes", nStore - s0, 1);
    s0 = nStore; r0 = nRecall;
    belowSwitch = 1'b1; tick(WIN + 4);
    pulseSw(1'b1); tick(2); pulseSw(1'b0); tick(3);
    check("R10 software save blocked in dip", nStore - s0, 0);
    check("R10 software restore blocked in dip", nRecall - r0, 0);
    rdChk(4, 0, "R8 read returns zero while inhibited");
    belowSwitch = 1'b0; tick(3);

    // Inhibit mode
    rstN = 1'b0; inhibitAuto = 1'b1; belowSwitch = 1'b1; tick(3);
    rstN = 1'b1; tick(1); belowSwitch = 1'b0; tick(RSC + 5);
    for (int a = 0; a < DEPTH; a++) refMem[a] = '0;
    wr(5, 8'h42); refMem[5] = 8'h42;
    s0 = nStore; b0 = busyCyc;
    belowSwitch = 1'b1; tick(WIN + STC + 5);
    check("R11 no busy drive", busyCyc - b0, 0);
    check("R11 no auto save", nStore - s0, 0);
    belowSwitch = 1'b0; tick(3);
    pulseSw(1'b1); tick(STC + 4);
    check("R11 software save still works", nStore - s0, 1);
    readAll("R12 readback in inhibit mode");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule